// File: doc/BRIEF.md
# Single-Stage Serial-to-Parallel Deserializer with Ring Divider

This block turns a serial bit stream into parallel words of N bits. Every bit-clock edge shifts one serial bit into a capture register. From the same bit clock, a ring of N flip-flops makes a divided word clock. Reset loads the ring with a block of ones and a block of zeros, so the divided clock has wide high and low phases and never produces a narrow pulse, whatever the ratio.

When the word clock rises, the N most recent bits, including the bit sampled on that edge, are copied into the parallel output. A valid strobe is raised for one bit clock at the same time. The conversion is done in a single stage at the bit rate, with no intermediate 1:2 splitting. Word alignment to a framing pattern is left to the logic downstream.

Top module: `ring_div_deser`

## Requirements
- R1: While `rst` is sampled high at a rising `clk` edge, the block loads its reset state. After that edge, `word_out` is all zeros, `word_vld` is 0 and `word_clk` is 1.
- R2: Count k as the number of rising `clk` edges after the last reset edge, with k = 0 right after reset. Then `word_clk` is 1 when (k mod N) < floor(N/2), and 0 otherwise. The clock is therefore high for floor(N/2) bit clocks and low for the remaining N - floor(N/2) in every period of N.
- R3: The first `word_vld` pulse follows edge k = N. Later pulses follow every edge k that is a multiple of N.
- R4: `word_vld` is high for exactly one bit clock in each word and is 0 after every other edge.
- R5: On a valid edge k, `word_out` holds the serial bits sampled at edges k-N+1 through k. The earliest of these bits is at bit N-1 (the MSB), and the bit from edge k is at bit 0.
- R6: Between valid pulses, `word_out` keeps its value.
- R7: Any N of 2 or more works, including odd N. For odd N, the high phase is the shorter one.
- R8: Asserting `rst` in the middle of a stream discards the partial word. Counting restarts from k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data, sampled on each rising edge |
| word_out | output | N | Parallel word, first received bit at the MSB |
| word_vld | output | 1 | One-cycle strobe marking a new word |
| word_clk | output | 1 | Divided word clock from the ring divider |

## Verification
The bench builds two instances from the same stimulus: one with N = 8 and one with N = 5. The even instance checks the balanced case, with four high and four low bit clocks per word. The odd instance checks the uneven split of two high and three low, and runs the ring lookahead tap on a different index. Random bits are mixed with all-ones and alternating runs, which expose swapped or shifted bit positions. A reset in the middle of a word checks that both dividers restart in phase with the new word boundary.

// File: rtl/ring_div_deser.sv
module ring_div_deser #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_in,
  output logic [N-1:0] word_out,
  output logic         word_vld,
  output logic         word_clk
);
  localparam int H    = N / 2;
  localparam int TAP  = H - 1;
  localparam int PREV = (H + N - 2) % N;
  localparam int PW   = (N > 2) ? $clog2(N) : 1;

  logic [N-1:0] ring;
  logic [N-2:0] shreg;
  logic [N-1:0] incoming;
  logic         rise;

  assign word_clk = ring[TAP];
  assign incoming = {shreg, ser_in};
  assign rise     = ~ring[TAP] & ring[PREV];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) ring[i] <= (i < H);
    end else begin
      ring <= {ring[N-2:0], ring[N-1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      shreg    <= incoming[N-2:0];
      word_vld <= rise;
      if (rise) word_out <= incoming;
    end
  end

  logic [PW-1:0] phase;
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= (int'(phase) == N - 1) ? '0 : phase + 1'b1;
  end

  a_r2_ring_weight: assert property (@(posedge clk) disable iff (rst)
    $countones(ring) == H);
  a_r2_duty: assert property (@(posedge clk) disable iff (rst)
    word_clk == (int'(phase) < H));
  a_r3_vld_on_boundary: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> (phase == '0) && word_clk);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!word_vld && !$past(rst)) |-> $stable(word_out));
endmodule

// File: tb/ring_div_deser_tb.sv
module ring_div_deser_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic [7:0] w8;
  logic [4:0] w5;
  logic v8, v5, c8, c5;

  int checks = 0;
  int fails = 0;
  int k = 0;
  bit armed = 0;
  bit bits [0:4095];

  always #10 clk = ~clk;

  ring_div_deser #(.N(8)) u_dut (.clk(clk), .rst(rst), .ser_in(ser_in),
    .word_out(w8), .word_vld(v8), .word_clk(c8));
  ring_div_deser #(.N(5)) u_dut_odd (.clk(clk), .rst(rst), .ser_in(ser_in),
    .word_out(w5), .word_vld(v5), .word_clk(c5));

  function automatic logic [31:0] exp_word(int n, int kk);
    logic [31:0] e = '0;
    for (int i = 0; i < n; i++) e[n-1-i] = bits[kk-n+i];
    return e;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s k=%0d actual=%h expected=%h", tag, k, act, exp);
    end
  endtask

  task automatic check_one(int n, logic [31:0] w, logic v, logic c, string nm);
    bit boundary = (k > 0) && (k % n == 0);
    if (k == 0) begin
      chk({"R1 reset word ", nm}, w, 0);
      chk({"R1 reset vld ", nm}, {31'b0, v}, 0);
      chk({"R1 reset wclk ", nm}, {31'b0, c}, 1);
    end else begin
      chk({"R2/R7 wclk ", nm}, {31'b0, c}, {31'b0, (k % n) < (n / 2)});
      chk({"R3/R4 vld ", nm}, {31'b0, v}, {31'b0, boundary});
      if (boundary) chk({"R5 word ", nm}, w, exp_word(n, k));
      else if (k >= n) chk({"R6 hold ", nm}, w, exp_word(n, k - (k % n)));
      else chk({"R6/R8 hold zero ", nm}, w, 0);
    end
  endtask

  task automatic step(bit r, bit d);
    @(negedge clk);
    if (armed) begin
      check_one(8, {24'b0, w8}, v8, c8, "n8");
      check_one(5, {27'b0, w5}, v5, c5, "n5");
    end
    rst = r;
    ser_in = d;
    if (r) begin
      k = 0;
      armed = 1;
    end else begin
      bits[k] = d;
      k++;
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 3; i++) step(1, 0);
    for (int i = 0; i < 200; i++) step(0, 1'($urandom));
    for (int i = 0; i < 40; i++) step(0, 1);
    for (int i = 0; i < 40; i++) step(0, 1'(i % 2));
    for (int i = 0; i < 13; i++) step(0, 1'($urandom));
    // R8: reset in the middle of a word
    for (int i = 0; i < 2; i++) step(1, 1);
    for (int i = 0; i < 200; i++) step(0, 1'($urandom));
    step(0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule